// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. On each reference clock in which counting is on, it adds a step. The usual step is a small default increment equal to the reference clock period. A separate compensation step is used on a few chosen cycles, so that the effective frequency can be trimmed without touching the default value.

Two mechanisms choose the compensation step. The first is a one-shot burst: a countdown register applies the compensation step on each of its remaining cycles, which makes a bounded phase correction. The second is a periodic slow trim: a reload counter applies the compensation step once every N cycles, which makes a continuous frequency correction.

The block can also act as a cycle timer. When the compare unit and its wrap option are both on, the count returns to zero after it reaches the compare value. Software uses a small word-addressed register strobe port. With it, software loads the count, reads the count coherently and clears a sticky wrap flag.

Top module: `drift_tod_counter`

## Requirements
- R1: After reset the count, the wrap flag, the match output, the read data and every register are zero, and counting is off.
- R2: The configuration word is at address 0. Bit 0 turns counting on, bits 7:4 hold the default step and bits 19:8 hold the compensation step. A read returns only those bits. While counting is on and no compensation is active, the count grows by the default step on every clock.
- R3: The burst register is at address 2 and is 24 bits wide. A write above 0xFFFFFF stores 0xFFFFFF. While the register is non-zero, each counting cycle adds the compensation step and lowers the register by one. A read returns the remaining cycles.
- R4: The trim period register is at address 3. A write of N stores N and restarts the phase. With N non-zero, every N-th counting cycle adds the compensation step and the others add the default step. With N zero, the trim is off.
- R5: A write to address 5 only stages the upper count word. A write to address 4 sets the count to {staged upper word, written lower word} at that clock edge. This load wins over the increment and works whether counting is on or off.
- R6: A read strobe returns data one cycle later. Reading address 4 returns the lower count word and captures the upper word. Reading address 5 returns that captured upper word, even if the live count has moved since.
- R7: A carry out of bit 63 sets the sticky wrap flag. The flag is visible on `tod_wrap` and at bit 0 of address 1. Writing 1 to that bit clears it and writing 0 has no effect.
- R8: Address 6 holds the compare controls: bit 1 turns the compare on and bit 0 enables the wrap to zero. Addresses 7 and 8 hold the lower and upper compare words. `cmp0_hit` is high while the compare is on and the current count equals the compare value. With the wrap enabled, the next counting cycle after a match loads zero, so one cycle lasts compare value plus one default step.
- R9: While counting is off, the count and the burst register hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_rd | input | 1 | One-cycle read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tod_count | output | 64 | Live time count |
| tod_wrap | output | 1 | Sticky counter wrap flag |
| cmp0_hit | output | 1 | Count equals compare value while the compare is on |

## Verification
The bench builds the block with its default parameters: a 64-bit count split into two 32-bit words, a 4-bit default step, a 12-bit compensation step, a 24-bit burst register, and both the slow-trim and compare-wrap variants generated. With these values the burst clamp can be reached from a single write. The carry out of bit 63 is reached within two cycles by preloading the count just below the top. The compare wrap and the trim period are driven with small values, so each expected count is a short sum of known steps.

// File: rtl/drift_tod_pkg.sv
package drift_tod_pkg;

   localparam int REG_ADDR_W = 4;

   typedef enum logic [REG_ADDR_W-1:0] {
      A_CFG  = 4'd0,
      A_STAT = 4'd1,
      A_BRST = 4'd2,
      A_TRIM = 4'd3,
      A_CLO  = 4'd4,
      A_CHI  = 4'd5,
      A_CCTL = 4'd6,
      A_C0LO = 4'd7,
      A_C0HI = 4'd8
   } tod_reg_e;

   // configuration word field positions
   localparam int CFG_RUN_BIT  = 0;
   localparam int CFG_DEF_LSB  = 4;
   localparam int CFG_COMP_LSB = 8;

   // compare control bits
   localparam int CCTL_WRAP_BIT = 0;
   localparam int CCTL_EN_BIT   = 1;

   // status bits
   localparam int STAT_WRAP_BIT = 0;

endpackage

// File: rtl/drift_tod_regs.sv
module drift_tod_regs
   import drift_tod_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 64,
   parameter int DEF_INC_W  = 4,
   parameter int COMP_INC_W = 12,
   parameter int BRST_W     = 24,
   parameter int TRIM_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [CNT_W-1:0]      count,
   input  logic                  wrap_flag,
   input  logic [BRST_W-1:0]     brst_rem,
   input  logic [TRIM_W-1:0]     trim_period,
   output logic                  run,
   output logic [DEF_INC_W-1:0]  def_inc,
   output logic [COMP_INC_W-1:0] comp_inc,
   output logic                  cmp_wrap_en,
   output logic                  cmp_en,
   output logic [CNT_W-1:0]      cmp0_val,
   output logic                  load,
   output logic [CNT_W-1:0]      load_val,
   output logic                  brst_wr,
   output logic [BRST_W-1:0]     brst_val,
   output logic                  trim_wr,
   output logic [TRIM_W-1:0]     trim_val,
   output logic                  wrap_clr
);

   localparam int HI_W = CNT_W - DATA_W;
   localparam logic [DATA_W-1:0] BRST_MAX = (DATA_W'(1) << BRST_W) - DATA_W'(1);

   logic                  cfg_run;
   logic [DEF_INC_W-1:0]  cfg_def;
   logic [COMP_INC_W-1:0] cfg_comp;
   logic                  cctl_wrap, cctl_en;
   logic [CNT_W-1:0]      cmp0_q;
   logic [HI_W-1:0]       hi_stage, hi_latch;
   logic [DATA_W-1:0]     rdata_q, rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_run   <= 1'b0;
         cfg_def   <= '0;
         cfg_comp  <= '0;
         cctl_wrap <= 1'b0;
         cctl_en   <= 1'b0;
         cmp0_q    <= '0;
         hi_stage  <= '0;
         hi_latch  <= '0;
         rdata_q   <= '0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               A_CFG: begin
                  cfg_run  <= reg_wdata[CFG_RUN_BIT];
                  cfg_def  <= reg_wdata[CFG_DEF_LSB +: DEF_INC_W];
                  cfg_comp <= reg_wdata[CFG_COMP_LSB +: COMP_INC_W];
               end
               A_CHI:  hi_stage <= reg_wdata[HI_W-1:0];
               A_CCTL: begin
                  cctl_wrap <= reg_wdata[CCTL_WRAP_BIT];
                  cctl_en   <= reg_wdata[CCTL_EN_BIT];
               end
               A_C0LO: cmp0_q[DATA_W-1:0]     <= reg_wdata;
               A_C0HI: cmp0_q[CNT_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
               default: ;
            endcase
         end
         if (reg_rd) begin
            rdata_q <= rd_mux;
            if (reg_addr == A_CLO) hi_latch <= count[CNT_W-1:DATA_W];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         A_CFG: begin
            rd_mux[CFG_RUN_BIT]                 = cfg_run;
            rd_mux[CFG_DEF_LSB +: DEF_INC_W]    = cfg_def;
            rd_mux[CFG_COMP_LSB +: COMP_INC_W]  = cfg_comp;
         end
         A_STAT: rd_mux[STAT_WRAP_BIT]  = wrap_flag;
         A_BRST: rd_mux[BRST_W-1:0]     = brst_rem;
         A_TRIM: rd_mux[TRIM_W-1:0]     = trim_period;
         A_CLO:  rd_mux                 = count[DATA_W-1:0];
         A_CHI:  rd_mux[HI_W-1:0]       = hi_latch;
         A_CCTL: begin
            rd_mux[CCTL_WRAP_BIT] = cctl_wrap;
            rd_mux[CCTL_EN_BIT]   = cctl_en;
         end
         A_C0LO: rd_mux              = cmp0_q[DATA_W-1:0];
         A_C0HI: rd_mux[HI_W-1:0]    = cmp0_q[CNT_W-1:DATA_W];
         default: rd_mux = '0;
      endcase
   end

   assign reg_rdata   = rdata_q;
   assign run         = cfg_run;
   assign def_inc     = cfg_def;
   assign comp_inc    = cfg_comp;
   assign cmp_wrap_en = cctl_wrap;
   assign cmp_en      = cctl_en;
   assign cmp0_val    = cmp0_q;

   assign load     = reg_wr && (reg_addr == A_CLO);
   assign load_val = {hi_stage, reg_wdata};
   assign brst_wr  = reg_wr && (reg_addr == A_BRST);
   assign brst_val = (reg_wdata > BRST_MAX) ? BRST_MAX[BRST_W-1:0] : reg_wdata[BRST_W-1:0];
   assign trim_wr  = reg_wr && (reg_addr == A_TRIM);
   assign trim_val = reg_wdata[TRIM_W-1:0];
   assign wrap_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[STAT_WRAP_BIT];

   // R6: read data only moves on a read strobe
   a_r6_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   // R6: the captured upper word only moves on a lower-word read
   a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == A_CLO) |=> $stable(hi_latch));

endmodule

// File: rtl/drift_tod_step.sv
module drift_tod_step #(
   parameter int DEF_INC_W  = 4,
   parameter int COMP_INC_W = 12,
   parameter int BRST_W     = 24,
   parameter int TRIM_W     = 32,
   parameter bit HAS_TRIM   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic [DEF_INC_W-1:0]  def_inc,
   input  logic [COMP_INC_W-1:0] comp_inc,
   input  logic                  brst_wr,
   input  logic [BRST_W-1:0]     brst_val,
   input  logic                  trim_wr,
   input  logic [TRIM_W-1:0]     trim_val,
   output logic [COMP_INC_W-1:0] step,
   output logic [BRST_W-1:0]     brst_rem,
   output logic [TRIM_W-1:0]     trim_period
);

   logic [BRST_W-1:0] brst_q;
   logic              brst_act;
   logic              trim_fire;

   assign brst_act = (brst_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                brst_q <= '0;
      else if (brst_wr)          brst_q <= brst_val;
      else if (run && brst_act)  brst_q <= brst_q - BRST_W'(1);
   end

   generate
      if (HAS_TRIM) begin : g_trim
         logic [TRIM_W-1:0] reload_q, rem_q;

         assign trim_fire   = (reload_q != '0) && (rem_q <= TRIM_W'(1));
         assign trim_period = reload_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               reload_q <= '0;
               rem_q    <= '0;
            end else if (trim_wr) begin
               reload_q <= trim_val;
               rem_q    <= trim_val;
            end else if (run && reload_q != '0) begin
               rem_q <= trim_fire ? reload_q : rem_q - TRIM_W'(1);
            end
         end

         // R4: an expiry restarts the period from the programmed value
         a_r4_trim_reload: assert property (@(posedge clk) disable iff (!rst_n)
            run && !trim_wr && trim_fire |=> rem_q == $past(reload_q));

         // R4: between expiries the remaining count walks down by one
         a_r4_trim_walk: assert property (@(posedge clk) disable iff (!rst_n)
            run && !trim_wr && reload_q != '0 && rem_q > TRIM_W'(1)
            |=> rem_q == $past(rem_q) - TRIM_W'(1));
      end else begin : g_notrim
         logic unused_trim;
         assign unused_trim = ^{trim_wr, trim_val};
         assign trim_fire   = 1'b0;
         assign trim_period = '0;
      end
   endgenerate

   assign step     = (brst_act || trim_fire) ? comp_inc : COMP_INC_W'(def_inc);
   assign brst_rem = brst_q;

   // R3: an active burst loses exactly one cycle per counting clock
   a_r3_burst_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      run && !brst_wr && brst_rem != '0 |=> brst_rem == $past(brst_rem) - BRST_W'(1));

   // R9: a stopped counter leaves the burst untouched
   a_r9_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !brst_wr |=> $stable(brst_rem));

endmodule

// File: rtl/drift_tod_core.sv
module drift_tod_core #(
   parameter int CNT_W         = 64,
   parameter int STEP_W        = 12,
   parameter bit HAS_CMP_WRAP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [STEP_W-1:0] step,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic              cmp_wrap_en,
   input  logic              cmp_en,
   input  logic [CNT_W-1:0]  cmp0_val,
   input  logic              wrap_clr,
   output logic [CNT_W-1:0]  count,
   output logic              wrap_flag,
   output logic              cmp_hit
);

   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] count_q;
   logic [SUM_W-1:0] sum;
   logic             hit, to_zero, carry_set, flag_q;

   assign hit = cmp_en && (count_q == cmp0_val);
   assign sum = {1'b0, count_q} + SUM_W'(step);

   generate
      if (HAS_CMP_WRAP) begin : g_wrap
         assign to_zero = run && cmp_wrap_en && hit;

         // R8: a counting cycle at the compare value lands on zero
         a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
            run && !load && cmp_wrap_en && cmp_en && count_q == cmp0_val |=> count_q == '0);
      end else begin : g_nowrap
         logic unused_wrap;
         assign unused_wrap = cmp_wrap_en;
         assign to_zero     = 1'b0;
      end
   endgenerate

   assign carry_set = run && !load && !to_zero && sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (load)    count_q <= load_val;
      else if (to_zero) count_q <= '0;
      else if (run)     count_q <= sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (carry_set)  flag_q <= 1'b1;
      else if (wrap_clr)   flag_q <= 1'b0;
   end

   assign count     = count_q;
   assign wrap_flag = flag_q;
   assign cmp_hit   = hit;

   // R5: a load is visible in the next cycle regardless of counting
   a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count_q == $past(load_val));

   // R9: no counting and no load means the count stays put
   a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !load |=> $stable(count_q));

   // R7: the flag stays set until a clear arrives
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_flag && !wrap_clr |=> wrap_flag);

   // R7: the flag only rises on a counting cycle
   a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrap_flag) |-> $past(run));

endmodule

// File: rtl/drift_tod_counter.sv
module drift_tod_counter
   import drift_tod_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 64,
   parameter int DEF_INC_W     = 4,
   parameter int COMP_INC_W    = 12,
   parameter int BRST_W        = 24,
   parameter int TRIM_W        = 32,
   parameter bit HAS_TRIM      = 1'b1,
   parameter bit HAS_CMP_WRAP  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [CNT_W-1:0]      tod_count,
   output logic                  tod_wrap,
   output logic                  cmp0_hit
);

   // elaboration-time parameter checks
   if (CNT_W != 2 * DATA_W) begin : g_chk_cnt
      $error("count must be exactly two data words");
   end
   if (COMP_INC_W < DEF_INC_W) begin : g_chk_step
      $error("compensation step narrower than default step");
   end
   if (CFG_COMP_LSB < CFG_DEF_LSB + DEF_INC_W || CFG_COMP_LSB + COMP_INC_W > DATA_W) begin : g_chk_cfg
      $error("configuration fields overlap or overflow the data word");
   end
   if (BRST_W > DATA_W || TRIM_W > DATA_W) begin : g_chk_cnts
      $error("compensation counters wider than the data word");
   end

   logic                  run, load, brst_wr, trim_wr, wrap_clr;
   logic                  cmp_wrap_en, cmp_en, wrap_flag;
   logic [DEF_INC_W-1:0]  def_inc;
   logic [COMP_INC_W-1:0] comp_inc, step;
   logic [CNT_W-1:0]      cmp0_val, load_val, count;
   logic [BRST_W-1:0]     brst_val, brst_rem;
   logic [TRIM_W-1:0]     trim_val, trim_period;

   drift_tod_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_INC_W(DEF_INC_W),
      .COMP_INC_W(COMP_INC_W), .BRST_W(BRST_W), .TRIM_W(TRIM_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .count(count), .wrap_flag(wrap_flag),
      .brst_rem(brst_rem), .trim_period(trim_period),
      .run(run), .def_inc(def_inc), .comp_inc(comp_inc),
      .cmp_wrap_en(cmp_wrap_en), .cmp_en(cmp_en), .cmp0_val(cmp0_val),
      .load(load), .load_val(load_val),
      .brst_wr(brst_wr), .brst_val(brst_val),
      .trim_wr(trim_wr), .trim_val(trim_val),
      .wrap_clr(wrap_clr)
   );

   drift_tod_step #(
      .DEF_INC_W(DEF_INC_W), .COMP_INC_W(COMP_INC_W),
      .BRST_W(BRST_W), .TRIM_W(TRIM_W), .HAS_TRIM(HAS_TRIM)
   ) u_step (
      .clk(clk), .rst_n(rst_n), .run(run),
      .def_inc(def_inc), .comp_inc(comp_inc),
      .brst_wr(brst_wr), .brst_val(brst_val),
      .trim_wr(trim_wr), .trim_val(trim_val),
      .step(step), .brst_rem(brst_rem), .trim_period(trim_period)
   );

   drift_tod_core #(
      .CNT_W(CNT_W), .STEP_W(COMP_INC_W), .HAS_CMP_WRAP(HAS_CMP_WRAP)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .step(step),
      .load(load), .load_val(load_val),
      .cmp_wrap_en(cmp_wrap_en), .cmp_en(cmp_en), .cmp0_val(cmp0_val),
      .wrap_clr(wrap_clr),
      .count(count), .wrap_flag(wrap_flag), .cmp_hit(cmp0_hit)
   );

   assign tod_count = count;
   assign tod_wrap  = wrap_flag;

endmodule

// File: tb/sim_drift_tod_counter.sv
module sim_drift_tod_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] tod_count;
   logic        tod_wrap;
   logic        cmp0_hit;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   drift_tod_counter u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tod_count(tod_count), .tod_wrap(tod_wrap), .cmp0_hit(cmp0_hit)
   );

   typedef struct packed {
      logic        is_rd;
      logic [3:0]  req;
      logic [3:0]  addr;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 25;
   // register-path vectors, counter stopped throughout
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'd5, 4'd5, 32'h1234_5678},  // R5 stage upper word
      '{1'b0, 4'd5, 4'd4, 32'h9ABC_DEF0},  // R5 load
      '{1'b1, 4'd6, 4'd4, 32'h9ABC_DEF0},  // R6 lower read
      '{1'b1, 4'd6, 4'd5, 32'h1234_5678},  // R6 captured upper
      '{1'b0, 4'd3, 4'd2, 32'h0123_4567},  // R3 above limit
      '{1'b1, 4'd3, 4'd2, 32'h00FF_FFFF},  // R3 clamped
      '{1'b0, 4'd3, 4'd2, 32'h0000_0010},
      '{1'b1, 4'd3, 4'd2, 32'h0000_0010},
      '{1'b0, 4'd3, 4'd2, 32'h0000_0000},
      '{1'b1, 4'd3, 4'd2, 32'h0000_0000},
      '{1'b0, 4'd4, 4'd3, 32'h0000_0007},  // R4 period
      '{1'b1, 4'd4, 4'd3, 32'h0000_0007},
      '{1'b0, 4'd2, 4'd0, 32'h0ABC_123E},  // R2 fields, run off
      '{1'b1, 4'd2, 4'd0, 32'h000C_1230},
      '{1'b0, 4'd8, 4'd6, 32'hFFFF_FFFE},  // R8 compare on, no wrap
      '{1'b1, 4'd8, 4'd6, 32'h0000_0002},
      '{1'b0, 4'd8, 4'd7, 32'h0000_0ABC},
      '{1'b1, 4'd8, 4'd7, 32'h0000_0ABC},
      '{1'b0, 4'd8, 4'd8, 32'h0000_0DEF},
      '{1'b1, 4'd8, 4'd8, 32'h0000_0DEF},
      '{1'b1, 4'd7, 4'd1, 32'h0000_0000},  // R7 flag clear
      '{1'b0, 4'd8, 4'd6, 32'h0000_0000},
      '{1'b0, 4'd4, 4'd3, 32'h0000_0000},
      '{1'b0, 4'd2, 4'd0, 32'h0000_0000},
      '{1'b1, 4'd2, 4'd0, 32'h0000_0000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      reg_rd   = 1'b1;
      @(negedge clk);
      reg_rd   = 1'b0;
      d        = reg_rdata;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rv;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk("R1 count", tod_count, 64'd0);
      chk("R1 wrap", {63'd0, tod_wrap}, 64'd0);
      chk("R1 hit", {63'd0, cmp0_hit}, 64'd0);
      chk("R1 rdata", {32'd0, reg_rdata}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_rd) begin
            rd(VECS[i].addr, rv);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), {32'd0, rv}, {32'd0, VECS[i].data});
         end else begin
            wr(VECS[i].addr, VECS[i].data);
         end
      end

      // R2 default step, then R9 hold
      wr(4'd5, 32'd0);
      wr(4'd4, 32'd0);
      wr(4'd0, 32'h51);
      chk("R2 start", tod_count, 64'd0);
      tick(10);
      chk("R2 ten steps", tod_count, 64'd50);
      wr(4'd0, 32'h50);
      chk("R2 last step", tod_count, 64'd55);
      tick(5);
      chk("R9 count holds", tod_count, 64'd55);

      // R3 burst of compensation steps
      wr(4'd4, 32'd0);
      wr(4'd2, 32'd4);
      wr(4'd0, 32'h921);
      tick(10);
      chk("R3 burst sum", tod_count, 64'd48);
      rd(4'd2, rv);
      chk("R3 burst drained", {32'd0, rv}, 64'd0);
      wr(4'd0, 32'h920);
      wr(4'd2, 32'd5);
      tick(3);
      rd(4'd2, rv);
      chk("R9 burst holds", {32'd0, rv}, 64'd5);
      wr(4'd2, 32'd0);

      // R4 periodic trim, then trim off
      wr(4'd4, 32'd0);
      wr(4'd3, 32'd3);
      wr(4'd0, 32'h721);
      tick(12);
      chk("R4 trim every third", tod_count, 64'd44);
      wr(4'd0, 32'h720);
      wr(4'd3, 32'd0);
      wr(4'd4, 32'd0);
      wr(4'd0, 32'h721);
      tick(9);
      chk("R4 zero period", tod_count, 64'd18);
      wr(4'd0, 32'h720);

      // R7 wrap flag
      wr(4'd5, 32'hFFFF_FFFF);
      wr(4'd4, 32'hFFFF_FFF8);
      chk("R7 flag clear before", {63'd0, tod_wrap}, 64'd0);
      wr(4'd0, 32'h41);
      tick(1);
      chk("R7 near top", tod_count, 64'hFFFF_FFFF_FFFF_FFFC);
      chk("R7 no flag yet", {63'd0, tod_wrap}, 64'd0);
      tick(1);
      chk("R7 wrapped count", tod_count, 64'd0);
      chk("R7 flag set", {63'd0, tod_wrap}, 64'd1);
      wr(4'd0, 32'h40);
      rd(4'd1, rv);
      chk("R7 status read", {32'd0, rv}, 64'd1);
      wr(4'd1, 32'd0);
      rd(4'd1, rv);
      chk("R7 write zero ignored", {32'd0, rv}, 64'd1);
      wr(4'd1, 32'd1);
      chk("R7 cleared pin", {63'd0, tod_wrap}, 64'd0);
      rd(4'd1, rv);
      chk("R7 cleared status", {32'd0, rv}, 64'd0);

      // R6 coherent upper word while running
      wr(4'd5, 32'd7);
      wr(4'd4, 32'hFFFF_FFE0);
      rd(4'd4, rv);
      chk("R6 lower word", {32'd0, rv}, 64'hFFFF_FFE0);
      wr(4'd0, 32'hF1);
      tick(10);
      rd(4'd5, rv);
      chk("R6 captured upper", {32'd0, rv}, 64'd7);
      chk("R6 live upper moved", {32'd0, tod_count[63:32]}, 64'd8);

      // R5 load while running
      wr(4'd0, 32'h31);
      wr(4'd5, 32'h22);
      chk("R5 staging no effect", {32'd0, tod_count[63:32]}, 64'd8);
      wr(4'd4, 32'h100);
      chk("R5 load lands", tod_count, 64'h0000_0022_0000_0100);
      tick(1);
      chk("R5 counts on", tod_count, 64'h0000_0022_0000_0103);
      wr(4'd0, 32'h30);

      // R8 compare with wrap to zero
      wr(4'd5, 32'd0);
      wr(4'd4, 32'd0);
      wr(4'd8, 32'd0);
      wr(4'd7, 32'd20);
      wr(4'd6, 32'd3);
      chk("R8 no match at zero", {63'd0, cmp0_hit}, 64'd0);
      wr(4'd0, 32'h51);
      tick(4);
      chk("R8 reach compare", tod_count, 64'd20);
      chk("R8 match pulse", {63'd0, cmp0_hit}, 64'd1);
      tick(1);
      chk("R8 wrapped", tod_count, 64'd0);
      chk("R8 match gone", {63'd0, cmp0_hit}, 64'd0);
      tick(5);
      chk("R8 full period", tod_count, 64'd0);
      wr(4'd0, 32'h50);
      wr(4'd6, 32'd2);
      wr(4'd4, 32'd0);
      wr(4'd0, 32'h51);
      tick(4);
      chk("R8 match without wrap", {63'd0, cmp0_hit}, 64'd1);
      tick(1);
      chk("R8 passes compare", tod_count, 64'd25);
      wr(4'd0, 32'h50);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule